// File: doc/BRIEF.md
# Base-Page Opcode Decoder for an 8-bit Accumulator CPU

This block turns one opcode byte from the base page of an 8-bit accumulator processor into a set of control fields. The fields are an operation class, destination and source register indices, a 16-bit register-pair index, a sub-operation code, a condition selector, the number of immediate bytes that follow, flags for a memory operand, 16-bit width, accumulator-misc group and high-page addressing, a restart vector, a coarse timing class, and an illegal-opcode indication. It does not execute anything, touch memory or produce flags. A fetch unit feeds it bytes, and the execute stage consumes the decoded word.

Decoding works from the bit fields of the byte rather than from a flat table. Let x = bits 7:6, y = bits 5:3, z = bits 2:0, p = bits 5:4 and q = bit 3. Register index 6 stands for the byte addressed by HL. It is flagged as a memory operand and puts the operation in a slower timing class.

Bytes enter on a valid/ready stream and decoded words leave on another. With `REG_OUT=1` (the default) a single register stage sits between them. A new byte is accepted whenever the stage is empty or its word is being taken in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output word holds. A producer must keep `in_op` steady while `in_valid` is high and `in_ready` is low. With `REG_OUT=0` the decoder is purely combinational and `in_ready` follows `out_ready`.

Top module: `opdec_top`

## Requirements
- R1: Class codes are CTRL=0, LOAD=1, ALU=2, INCDEC=3, STACK=4, JUMP=5, CALL=6, RET=7, RST=8, PREFIX=9. Register indices are B=0, C=1, D=2, E=3, H=4, L=5, (HL)=6, A=7. Pair indices are BC=0, DE=1, HL=2, SP=3. Every field that an opcode does not use reads 0 (for example, 0x00 gives all fields 0).
- R2: For 0x40..0x7F except 0x76, the class is LOAD with dst=y and src=z. The memory flag is set when either index is 6. 0x76 is CTRL with sub=2 (halt).
- R3: For 0x80..0xBF, the class is ALU with sub=y (ADD=0, ADC=1, SUB=2, SBC=3, AND=4, XOR=5, OR=6, CP=7), dst=7 and src=z. The memory flag is set when z=6.
- R4: Opcodes 11yyy110 are ALU with sub=y, dst=7 and a 1-byte immediate. Opcodes 00yyy111 are ALU with the accumulator-misc flag set and sub=y (0..7: rotate-left-circular, rotate-right-circular, rotate-left, rotate-right, decimal adjust, complement, set carry, complement carry).
- R5: 00yyy100 is INCDEC with sub=0, and 00yyy101 is INCDEC with sub=1; both have dst=src=y. 00yyy110 is LOAD with dst=y and a 1-byte immediate. In all three, the memory flag is set when y=6.
- R6: 00pp0001 is LOAD with a 2-byte immediate. 00pp1001 is ALU with sub=0. 00pp0011 is INCDEC with sub=0, and 00pp1011 is INCDEC with sub=1. All four have pair=p and the wide flag set. 00pp0010 is LOAD with src=7, pair=p and the memory flag; 00pp1010 is the same with dst=7 instead of src=7.
- R7: 11pp0101 is STACK with sub=0 (push) and 11pp0001 is STACK with sub=1 (pop). Both have pair=p, where 3 denotes the AF pair.
- R8: 11yyy111 is RST with restart vector y*8 (0x00..0x38).
- R9: The high-page flag is set for 0xE0 (LOAD, src=7, 1-byte immediate, memory), 0xF0 (as 0xE0 but dst=7), 0xE2 (LOAD, src=7, memory) and 0xF2 (as 0xE2 but dst=7). The following use pair=3: 0x08 is LOAD with a 2-byte immediate, memory and wide. 0xE8 is ALU with sub=0, wide and a 1-byte immediate. 0xF8 is LOAD, wide, with a 1-byte immediate. 0xF9 is LOAD, wide. 0xEA is LOAD with src=7, a 2-byte immediate and memory; 0xFA is the same with dst=7.
- R10: Conditional forms set cond_en with cond=bits 4:3 (NZ=0, Z=1, NC=2, C=3): 0x20/28/30/38 are JUMP with a 1-byte immediate, 0xC2/CA/D2/DA are JUMP with a 2-byte immediate, 0xC4/CC/D4/DC are CALL with a 2-byte immediate, and 0xC0/C8/D0/D8 are RET. The unconditional forms are: 0x18 is JUMP with a 1-byte immediate; 0xC3 is JUMP with a 2-byte immediate; 0xE9 is JUMP with pair=2; 0xCD is CALL with a 2-byte immediate; 0xC9 is RET with sub=0; 0xD9 is RET with sub=1.
- R11: 0xCB is class PREFIX. 0x00, 0x10, 0xF3 and 0xFB are CTRL with sub=0, 1, 3 and 4 respectively.
- R12: 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD assert illegal, with every other field 0.
- R13: The timing class is chosen by the first rule that applies:
  - long (2) for STACK, JUMP, CALL, RET or RST, or for any opcode with a 2-byte immediate;
  - medium (1) for a memory operand, a 1-byte immediate or the wide flag;
  - short (0) otherwise.
- R14: After reset, `out_valid` is 0. The input is accepted when `!out_valid || out_ready`, and the decoded word appears one cycle after acceptance. The output word and `out_valid` hold while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode byte present |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| in_op | input | 8 | Opcode byte |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_cls | output | 4 | Operation class |
| out_dst | output | 3 | Destination register index |
| out_src | output | 3 | Source register index |
| out_pair | output | 2 | Register-pair index |
| out_sub | output | 3 | Sub-operation code |
| out_cond_en | output | 1 | Operation is conditional |
| out_cond | output | 2 | Condition selector |
| out_imm_len | output | 2 | Immediate bytes following (0..2) |
| out_mem | output | 1 | Memory operand |
| out_wide | output | 1 | 16-bit data operation |
| out_acc_misc | output | 1 | Accumulator-misc group |
| out_high_page | output | 1 | Address is 0xFF00 plus a byte |
| out_rst_vec | output | 8 | Restart vector |
| out_timing | output | 2 | Coarse timing class |
| out_illegal | output | 1 | Opcode not defined on this page |

## Verification
The properties assume that `in_op` carries a defined byte whenever `in_valid` is high, and that a stalled producer keeps `in_valid` and `in_op` steady until `in_ready` returns. The properties also assume `out_ready` is a defined level at every rising edge. The stimulus meets these assumptions in three ways:
- It drives only integer-derived bytes.
- It changes inputs only at the falling clock edge.
- During the deliberate stall, it presents one byte and leaves it unchanged until the consumer frees the stage.

Every one of the 256 base-page bytes is sent once, and each decoded field is compared with an independently written per-range model.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  typedef enum logic [3:0] {
    CL_CTRL   = 4'd0,
    CL_LOAD   = 4'd1,
    CL_ALU    = 4'd2,
    CL_INCDEC = 4'd3,
    CL_STACK  = 4'd4,
    CL_JUMP   = 4'd5,
    CL_CALL   = 4'd6,
    CL_RET    = 4'd7,
    CL_RST    = 4'd8,
    CL_PREFIX = 4'd9
  } op_class_e;

  localparam int OP_W   = 8;
  localparam int REG_W  = 3;
  localparam int PAIR_W = 2;
  localparam int TM_W   = 2;

  localparam logic [REG_W-1:0]  REG_ACC = 3'd7;
  localparam logic [REG_W-1:0]  REG_IND = 3'd6;
  localparam logic [PAIR_W-1:0] PAIR_HL = 2'd2;
  localparam logic [PAIR_W-1:0] PAIR_SP = 2'd3;

  localparam logic [TM_W-1:0] TM_SHORT = 2'd0;
  localparam logic [TM_W-1:0] TM_MED   = 2'd1;
  localparam logic [TM_W-1:0] TM_LONG  = 2'd2;

  typedef struct packed {
    op_class_e          cls;
    logic [REG_W-1:0]   dst;
    logic [REG_W-1:0]   src;
    logic [PAIR_W-1:0]  pair;
    logic [2:0]         sub;
    logic               cen;
    logic [1:0]         cc;
    logic [1:0]         imm;
    logic               mem;
    logic               wide;
    logic               misc;
    logic               high;
    logic [2:0]         rst_idx;
    logic [TM_W-1:0]    tm;
    logic               ill;
  } dec_t;

  localparam int DEC_W = $bits(dec_t);

endpackage

// File: rtl/opdec_core.sv
module opdec_core
  import opdec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);

  logic [1:0] fx;
  logic [2:0] fy;
  logic [2:0] fz;
  logic [1:0] fp;
  logic       fq;

  assign fx = op[7:6];
  assign fy = op[5:3];
  assign fz = op[2:0];
  assign fp = op[5:4];
  assign fq = op[3];

  always_comb begin
    dec = '0;
    case (fx)
      2'd0: begin
        case (fz)
          3'd0: begin
            case (fy)
              3'd0: dec.cls = CL_CTRL;
              3'd1: begin
                dec.cls  = CL_LOAD;
                dec.imm  = 2'd2;
                dec.mem  = 1'b1;
                dec.pair = PAIR_SP;
                dec.wide = 1'b1;
              end
              3'd2: begin
                dec.cls = CL_CTRL;
                dec.sub = 3'd1;
              end
              3'd3: begin
                dec.cls = CL_JUMP;
                dec.imm = 2'd1;
              end
              default: begin
                dec.cls = CL_JUMP;
                dec.imm = 2'd1;
                dec.cen = 1'b1;
                dec.cc  = fy[1:0];
              end
            endcase
          end
          3'd1: begin
            dec.pair = fp;
            dec.wide = 1'b1;
            if (!fq) begin
              dec.cls = CL_LOAD;
              dec.imm = 2'd2;
            end else begin
              dec.cls = CL_ALU;
            end
          end
          3'd2: begin
            dec.cls  = CL_LOAD;
            dec.pair = fp;
            dec.mem  = 1'b1;
            if (fq) dec.dst = REG_ACC;
            else    dec.src = REG_ACC;
          end
          3'd3: begin
            dec.cls  = CL_INCDEC;
            dec.pair = fp;
            dec.wide = 1'b1;
            dec.sub  = {2'b00, fq};
          end
          3'd4, 3'd5: begin
            dec.cls = CL_INCDEC;
            dec.dst = fy;
            dec.src = fy;
            dec.mem = (fy == REG_IND);
            dec.sub = {2'b00, fz[0]};
          end
          3'd6: begin
            dec.cls = CL_LOAD;
            dec.dst = fy;
            dec.imm = 2'd1;
            dec.mem = (fy == REG_IND);
          end
          default: begin
            dec.cls  = CL_ALU;
            dec.misc = 1'b1;
            dec.sub  = fy;
          end
        endcase
      end
      2'd1: begin
        if (fy == REG_IND && fz == REG_IND) begin
          dec.cls = CL_CTRL;
          dec.sub = 3'd2;
        end else begin
          dec.cls = CL_LOAD;
          dec.dst = fy;
          dec.src = fz;
          dec.mem = (fy == REG_IND) || (fz == REG_IND);
        end
      end
      2'd2: begin
        dec.cls = CL_ALU;
        dec.sub = fy;
        dec.dst = REG_ACC;
        dec.src = fz;
        dec.mem = (fz == REG_IND);
      end
      default: begin
        case (fz)
          3'd0: begin
            if (!fy[2]) begin
              dec.cls = CL_RET;
              dec.cen = 1'b1;
              dec.cc  = fy[1:0];
            end else begin
              case (fy[1:0])
                2'd0: begin
                  dec.cls  = CL_LOAD;
                  dec.src  = REG_ACC;
                  dec.imm  = 2'd1;
                  dec.mem  = 1'b1;
                  dec.high = 1'b1;
                end
                2'd1: begin
                  dec.cls  = CL_ALU;
                  dec.wide = 1'b1;
                  dec.pair = PAIR_SP;
                  dec.imm  = 2'd1;
                end
                2'd2: begin
                  dec.cls  = CL_LOAD;
                  dec.dst  = REG_ACC;
                  dec.imm  = 2'd1;
                  dec.mem  = 1'b1;
                  dec.high = 1'b1;
                end
                default: begin
                  dec.cls  = CL_LOAD;
                  dec.wide = 1'b1;
                  dec.pair = PAIR_SP;
                  dec.imm  = 2'd1;
                end
              endcase
            end
          end
          3'd1: begin
            if (!fq) begin
              dec.cls  = CL_STACK;
              dec.sub  = 3'd1;
              dec.pair = fp;
            end else begin
              case (fp)
                2'd0: dec.cls = CL_RET;
                2'd1: begin
                  dec.cls = CL_RET;
                  dec.sub = 3'd1;
                end
                2'd2: begin
                  dec.cls  = CL_JUMP;
                  dec.pair = PAIR_HL;
                end
                default: begin
                  dec.cls  = CL_LOAD;
                  dec.wide = 1'b1;
                  dec.pair = PAIR_SP;
                end
              endcase
            end
          end
          3'd2: begin
            if (!fy[2]) begin
              dec.cls = CL_JUMP;
              dec.imm = 2'd2;
              dec.cen = 1'b1;
              dec.cc  = fy[1:0];
            end else begin
              dec.cls  = CL_LOAD;
              dec.mem  = 1'b1;
              dec.high = !fy[0];
              dec.imm  = fy[0] ? 2'd2 : 2'd0;
              if (fy[1]) dec.dst = REG_ACC;
              else       dec.src = REG_ACC;
            end
          end
          3'd3: begin
            case (fy)
              3'd0: begin
                dec.cls = CL_JUMP;
                dec.imm = 2'd2;
              end
              3'd1: dec.cls = CL_PREFIX;
              3'd6: begin
                dec.cls = CL_CTRL;
                dec.sub = 3'd3;
              end
              3'd7: begin
                dec.cls = CL_CTRL;
                dec.sub = 3'd4;
              end
              default: dec.ill = 1'b1;
            endcase
          end
          3'd4: begin
            if (!fy[2]) begin
              dec.cls = CL_CALL;
              dec.imm = 2'd2;
              dec.cen = 1'b1;
              dec.cc  = fy[1:0];
            end else begin
              dec.ill = 1'b1;
            end
          end
          3'd5: begin
            if (!fq) begin
              dec.cls  = CL_STACK;
              dec.pair = fp;
            end else if (fp == 2'd0) begin
              dec.cls = CL_CALL;
              dec.imm = 2'd2;
            end else begin
              dec.ill = 1'b1;
            end
          end
          3'd6: begin
            dec.cls = CL_ALU;
            dec.sub = fy;
            dec.dst = REG_ACC;
            dec.imm = 2'd1;
          end
          default: begin
            dec.cls     = CL_RST;
            dec.rst_idx = fy;
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/opdec_timing.sv
module opdec_timing
  import opdec_pkg::*;
(
  input  op_class_e       cls,
  input  logic [1:0]      imm,
  input  logic            mem,
  input  logic            wide,
  output logic [TM_W-1:0] tm
);

  logic is_flow;

  assign is_flow = (cls == CL_STACK) || (cls == CL_JUMP) || (cls == CL_CALL) ||
                   (cls == CL_RET)   || (cls == CL_RST);

  always_comb begin
    if (is_flow || imm == 2'd2)            tm = TM_LONG;
    else if (mem || imm == 2'd1 || wide)   tm = TM_MED;
    else                                   tm = TM_SHORT;
  end

endmodule

// File: rtl/opdec_stage.sv
module opdec_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_d
);

  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_d;
        end
      end

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_d     = dat_q;

      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_d)); // R14

      AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R14
    end else begin : g_thru
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_d     = in_d;
    end
  endgenerate

endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_op,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_cls,
  output logic [2:0]  out_dst,
  output logic [2:0]  out_src,
  output logic [1:0]  out_pair,
  output logic [2:0]  out_sub,
  output logic        out_cond_en,
  output logic [1:0]  out_cond,
  output logic [1:0]  out_imm_len,
  output logic        out_mem,
  output logic        out_wide,
  output logic        out_acc_misc,
  output logic        out_high_page,
  output logic [7:0]  out_rst_vec,
  output logic [1:0]  out_timing,
  output logic        out_illegal
);

  dec_t            core_dec;
  dec_t            full_dec;
  dec_t            held;
  logic [TM_W-1:0] tm_w;
  logic [DEC_W-1:0] bus_out;

  opdec_core u_core (
    .op  (in_op),
    .dec (core_dec)
  );

  opdec_timing u_timing (
    .cls  (core_dec.cls),
    .imm  (core_dec.imm),
    .mem  (core_dec.mem),
    .wide (core_dec.wide),
    .tm   (tm_w)
  );

  always_comb begin
    full_dec    = core_dec;
    full_dec.tm = tm_w;
  end

  opdec_stage #(.W(DEC_W), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_d      (full_dec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_d     (bus_out)
  );

  assign held          = dec_t'(bus_out);
  assign out_cls       = held.cls;
  assign out_dst       = held.dst;
  assign out_src       = held.src;
  assign out_pair      = held.pair;
  assign out_sub       = held.sub;
  assign out_cond_en   = held.cen;
  assign out_cond      = held.cc;
  assign out_imm_len   = held.imm;
  assign out_mem       = held.mem;
  assign out_wide      = held.wide;
  assign out_acc_misc  = held.misc;
  assign out_high_page = held.high;
  assign out_rst_vec   = {2'b00, held.rst_idx, 3'b000};
  assign out_timing    = held.tm;
  assign out_illegal   = held.ill;

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_cls == 4'd0 && out_imm_len == 2'd0 && !out_mem); // R12

  AST_MEM_SLOWER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mem |-> out_timing != TM_SHORT); // R13

  AST_COND_ON_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cond_en |-> out_cls == 4'd5 || out_cls == 4'd6 || out_cls == 4'd7); // R10

  AST_PREFIX_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cls == 4'd9 |-> out_imm_len == 2'd0 && !out_illegal); // R11

  AST_RST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cls == 4'd8 |-> out_rst_vec[2:0] == 3'd0 && out_timing == TM_LONG); // R8

  AST_NO_IMM3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_imm_len != 2'd3); // R1

endmodule

// File: tb/opdec_top_bench.sv
`timescale 1ns/1ps
module opdec_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_op = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_cls;
  logic [2:0] out_dst, out_src, out_sub;
  logic [1:0] out_pair, out_cond, out_imm_len, out_timing;
  logic       out_cond_en, out_mem, out_wide, out_acc_misc, out_high_page, out_illegal;
  logic [7:0] out_rst_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opdec_top u_opdec_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls), .out_dst(out_dst),
    .out_src(out_src), .out_pair(out_pair), .out_sub(out_sub), .out_cond_en(out_cond_en),
    .out_cond(out_cond), .out_imm_len(out_imm_len), .out_mem(out_mem), .out_wide(out_wide),
    .out_acc_misc(out_acc_misc), .out_high_page(out_high_page), .out_rst_vec(out_rst_vec),
    .out_timing(out_timing), .out_illegal(out_illegal)
  );

  typedef struct {
    int cls, dst, src, pair, sub, cen, cc, imm, mem, wide, misc, high, vec, tm, ill;
  } ref_t;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_bad_op(input int o);
    return o == 'hD3 || o == 'hDB || o == 'hDD || o == 'hE3 || o == 'hE4 || o == 'hEB ||
           o == 'hEC || o == 'hED || o == 'hF4 || o == 'hFC || o == 'hFD;
  endfunction

  function automatic ref_t model(input int o);
    ref_t r;
    int m7, mf;
    r = '{default: 0};
    m7 = o & 'hC7;
    mf = o & 'hCF;
    if (is_bad_op(o)) r.ill = 1;
    else if (o == 'h76) begin r.cls = 0; r.sub = 2; end
    else if (o >= 'h40 && o <= 'h7F) begin
      r.cls = 1; r.dst = (o >> 3) & 7; r.src = o & 7; r.mem = (r.dst == 6 || r.src == 6);
    end else if (o >= 'h80 && o <= 'hBF) begin
      r.cls = 2; r.sub = (o >> 3) & 7; r.dst = 7; r.src = o & 7; r.mem = (r.src == 6);
    end else if (m7 == 'hC6) begin r.cls = 2; r.sub = (o >> 3) & 7; r.dst = 7; r.imm = 1; end
    else if (m7 == 'hC7) begin r.cls = 8; r.vec = o & 'h38; end
    else if (m7 == 'h07) begin r.cls = 2; r.misc = 1; r.sub = (o >> 3) & 7; end
    else if (m7 == 'h04 || m7 == 'h05) begin
      r.cls = 3; r.dst = (o >> 3) & 7; r.src = r.dst; r.mem = (r.dst == 6); r.sub = o & 1;
    end else if (m7 == 'h06) begin r.cls = 1; r.dst = (o >> 3) & 7; r.imm = 1; r.mem = (r.dst == 6); end
    else if (mf == 'h01) begin r.cls = 1; r.pair = (o >> 4) & 3; r.imm = 2; r.wide = 1; end
    else if (mf == 'h09) begin r.cls = 2; r.pair = (o >> 4) & 3; r.wide = 1; end
    else if (mf == 'h03 || mf == 'h0B) begin r.cls = 3; r.pair = (o >> 4) & 3; r.wide = 1; r.sub = (o >> 3) & 1; end
    else if (mf == 'h02) begin r.cls = 1; r.pair = (o >> 4) & 3; r.mem = 1; r.src = 7; end
    else if (mf == 'h0A) begin r.cls = 1; r.pair = (o >> 4) & 3; r.mem = 1; r.dst = 7; end
    else if (mf == 'hC1) begin r.cls = 4; r.sub = 1; r.pair = (o >> 4) & 3; end
    else if (mf == 'hC5) begin r.cls = 4; r.pair = (o >> 4) & 3; end
    else if (o == 'h00) r.cls = 0;
    else if (o == 'h10) begin r.cls = 0; r.sub = 1; end
    else if (o == 'hF3) begin r.cls = 0; r.sub = 3; end
    else if (o == 'hFB) begin r.cls = 0; r.sub = 4; end
    else if (o == 'hCB) r.cls = 9;
    else if (o == 'h08) begin r.cls = 1; r.imm = 2; r.mem = 1; r.pair = 3; r.wide = 1; end
    else if (o == 'hE0) begin r.cls = 1; r.src = 7; r.imm = 1; r.mem = 1; r.high = 1; end
    else if (o == 'hF0) begin r.cls = 1; r.dst = 7; r.imm = 1; r.mem = 1; r.high = 1; end
    else if (o == 'hE2) begin r.cls = 1; r.src = 7; r.mem = 1; r.high = 1; end
    else if (o == 'hF2) begin r.cls = 1; r.dst = 7; r.mem = 1; r.high = 1; end
    else if (o == 'hEA) begin r.cls = 1; r.src = 7; r.imm = 2; r.mem = 1; end
    else if (o == 'hFA) begin r.cls = 1; r.dst = 7; r.imm = 2; r.mem = 1; end
    else if (o == 'hE8) begin r.cls = 2; r.wide = 1; r.pair = 3; r.imm = 1; end
    else if (o == 'hF8) begin r.cls = 1; r.wide = 1; r.pair = 3; r.imm = 1; end
    else if (o == 'hF9) begin r.cls = 1; r.wide = 1; r.pair = 3; end
    else if (o == 'h18) begin r.cls = 5; r.imm = 1; end
    else if (o == 'h20 || o == 'h28 || o == 'h30 || o == 'h38) begin r.cls = 5; r.imm = 1; r.cen = 1; r.cc = (o >> 3) & 3; end
    else if (o == 'hC2 || o == 'hCA || o == 'hD2 || o == 'hDA) begin r.cls = 5; r.imm = 2; r.cen = 1; r.cc = (o >> 3) & 3; end
    else if (o == 'hC4 || o == 'hCC || o == 'hD4 || o == 'hDC) begin r.cls = 6; r.imm = 2; r.cen = 1; r.cc = (o >> 3) & 3; end
    else if (o == 'hC0 || o == 'hC8 || o == 'hD0 || o == 'hD8) begin r.cls = 7; r.cen = 1; r.cc = (o >> 3) & 3; end
    else if (o == 'hC3) begin r.cls = 5; r.imm = 2; end
    else if (o == 'hE9) begin r.cls = 5; r.pair = 2; end
    else if (o == 'hCD) begin r.cls = 6; r.imm = 2; end
    else if (o == 'hC9) r.cls = 7;
    else if (o == 'hD9) begin r.cls = 7; r.sub = 1; end
    if (r.cls >= 4 && r.cls <= 8 || r.imm == 2) r.tm = 2;
    else if (r.mem != 0 || r.imm == 1 || r.wide != 0) r.tm = 1;
    else r.tm = 0;
    return r;
  endfunction

  function automatic string tag_of(input int o);
    int m7, mf;
    m7 = o & 'hC7;
    mf = o & 'hCF;
    if (is_bad_op(o)) return "R12";
    if (o >= 'h40 && o <= 'h7F) return "R2";
    if (o >= 'h80 && o <= 'hBF) return "R3";
    if (m7 == 'hC6 || m7 == 'h07) return "R4";
    if (m7 == 'h04 || m7 == 'h05 || m7 == 'h06) return "R5";
    if (mf == 'h01 || mf == 'h09 || mf == 'h03 || mf == 'h0B || mf == 'h02 || mf == 'h0A) return "R6";
    if ((o & 'hCB) == 'hC1) return "R7";
    if (m7 == 'hC7) return "R8";
    if (o == 'hE0 || o == 'hF0 || o == 'hE2 || o == 'hF2 || o == 'hEA || o == 'hFA ||
        o == 'h08 || o == 'hE8 || o == 'hF8 || o == 'hF9) return "R9";
    if (o == 'h00 || o == 'h10 || o == 'hF3 || o == 'hFB || o == 'hCB) return "R11";
    return "R10";
  endfunction

  task automatic send_one(input int o);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = 8'(o);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare_all(input int o);
    ref_t e;
    string t;
    e = model(o);
    t = tag_of(o);
    chk(t, $sformatf("op=%02h valid", o), int'(out_valid), 1);
    chk(t, $sformatf("op=%02h cls", o), int'(out_cls), e.cls);
    chk(t, $sformatf("op=%02h dst", o), int'(out_dst), e.dst);
    chk(t, $sformatf("op=%02h src", o), int'(out_src), e.src);
    chk(t, $sformatf("op=%02h pair", o), int'(out_pair), e.pair);
    chk(t, $sformatf("op=%02h sub", o), int'(out_sub), e.sub);
    chk(t, $sformatf("op=%02h cen", o), int'(out_cond_en), e.cen);
    chk(t, $sformatf("op=%02h cond", o), int'(out_cond), e.cc);
    chk(t, $sformatf("op=%02h imm", o), int'(out_imm_len), e.imm);
    chk(t, $sformatf("op=%02h mem", o), int'(out_mem), e.mem);
    chk(t, $sformatf("op=%02h wide", o), int'(out_wide), e.wide);
    chk(t, $sformatf("op=%02h misc", o), int'(out_acc_misc), e.misc);
    chk(t, $sformatf("op=%02h high", o), int'(out_high_page), e.high);
    chk(t, $sformatf("op=%02h vec", o), int'(out_rst_vec), e.vec);
    chk(t, $sformatf("op=%02h ill", o), int'(out_illegal), e.ill);
    chk("R13", $sformatf("op=%02h timing", o), int'(out_timing), e.tm);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R14", "reset out_valid", int'(out_valid), 0);
    chk("R14", "reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 256; o++) begin
      send_one(o);
      compare_all(o);
    end
  endtask

  task automatic t_spots;
    send_one('h00);
    chk("R1", "nop cls", int'(out_cls), 0);
    chk("R1", "nop timing", int'(out_timing), 0);
    chk("R1", "nop vec", int'(out_rst_vec), 0);
    send_one('h76);
    chk("R2", "halt sub", int'(out_sub), 2);
    chk("R2", "halt mem", int'(out_mem), 0);
    send_one('hF5);
    chk("R7", "push AF pair", int'(out_pair), 3);
    send_one('hFF);
    chk("R8", "rst 38 vec", int'(out_rst_vec), 'h38);
    send_one('hBE);
    chk("R3", "cp (hl) timing", int'(out_timing), 1);
    @(negedge clk);
    chk("R14", "drain out_valid", int'(out_valid), 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_op = 8'h3E;
    @(negedge clk);
    chk("R14", "stall valid", int'(out_valid), 1);
    chk("R14", "stall in_ready low", int'(in_ready), 0);
    chk("R14", "first word cls", int'(out_cls), 1);
    in_op = 8'hC6;
    @(negedge clk);
    @(negedge clk);
    chk("R14", "held cls", int'(out_cls), 1);
    chk("R14", "held dst", int'(out_dst), 7);
    chk("R14", "held imm", int'(out_imm_len), 1);
    chk("R14", "held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R14", "second word cls", int'(out_cls), 2);
    chk("R14", "second word sub", int'(out_sub), 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R14", "emptied", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep();
    t_spots();
    t_backpressure();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R14 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule